// File: doc/BRIEF.md
# Integer ALU with Immediate-Count Shifter

This block is the arithmetic and logic unit for the register-to-register instructions of a 32-bit processor. Each cycle it takes a 5-bit operation code, two operands and a 5-bit shift amount taken from the instruction word. It produces the operation result combinationally on the same cycle. On a clock edge where the caller raises `exec_en`, it captures three status flags: negative, zero and carry.

There are two groups of operations. The two-operand group is add, subtract, AND, OR and XOR. The one-operand group works on `op_a` only: logical left shift, left rotate, logical right shift, arithmetic right shift and bitwise complement.

The shift amount always comes from the instruction's immediate field. There is no right-rotate operation. Software gets a right rotate by N by rotating left by 32−N. Register selection, operand routing and write-back are handled elsewhere. A compare is a subtract whose result the caller does not write back, keeping only the flags.

Top module: `alu_core`

## Requirements
- R1: Opcode 10101 (add) gives `result = op_a + op_b` modulo 2^32. The captured carry flag is the carry out of bit 31.
- R2: Opcode 10110 (subtract) gives `result = op_a − op_b` modulo 2^32. The captured carry flag is the carry out of `op_a + ~op_b + 1`, which is 1 exactly when `op_a >= op_b` unsigned.
- R3: Opcodes 10111, 11000 and 11001 give the bitwise AND, OR and XOR of the operands. Every logic and shift operation clears the carry flag.
- R4: Opcode 10000 shifts `op_a` left by `shamt` places (0 to 31) and fills the vacated low bits with zeros.
- R5: Opcode 10001 rotates `op_a` left by `shamt` places, and every bit shifted out re-enters at the bottom. For any N from 1 to 31, a left rotate by 32−N equals a right rotate by N.
- R6: Opcode 10010 shifts `op_a` right by `shamt` places and fills the vacated high bits with zeros.
- R7: Opcode 10011 shifts `op_a` right by `shamt` places and fills the vacated high bits with copies of `op_a[31]`.
- R8: With `shamt` = 0, each of the four shift opcodes returns `op_a` unchanged.
- R9: Opcode 10100 returns `~op_a` for every value of `shamt`. The shift amount has no effect on this operation.
- R10: On a rising clock edge with `exec_en` high and one of the ten opcodes above, the flags become: `flag_n` = `result[31]`, and `flag_z` = 1 when all 32 result bits are zero. Both are taken from the result presented before that edge.
- R11: The flags keep their value across an edge where `exec_en` is low, or where the opcode is none of the ten above. An unrecognised opcode drives `result` to zero.
- R12: While `rst_n` is low, all three flags are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; flags update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| exec_en | input | 1 | Capture the flags of the current operation at the next edge |
| opcode | input | 5 | Operation code |
| op_a | input | 32 | First operand; the only source for one-operand operations |
| op_b | input | 32 | Second operand for two-operand operations |
| shamt | input | 5 | Immediate shift amount, 0 to 31 |
| result | output | 32 | Combinational operation result |
| flag_n | output | 1 | Registered negative flag |
| flag_z | output | 1 | Registered zero flag |
| flag_c | output | 1 | Registered carry flag |

## Verification
The bench runs every shift and rotate opcode over all 32 amounts on patterns with set sign bits, alternating bits and single bits. This exposes a shifter stage wired to the wrong power of two, a right shift that fills with the sign when it should not (or fails to when it should), and a rotate that drops the wrapped bits. Subtraction is driven with equal, larger and smaller operands, because an inverted carry-out convention only shows up at those borders. The complement opcode is repeated with every shift amount to show the amount is truly ignored. The bench also interleaves idle cycles and undefined opcodes; a flag register that loads unconditionally would then take values from the wrong operation.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int OPC_W = 5;

    typedef enum logic [OPC_W-1:0] {
        OP_SHL = 5'b10000,
        OP_ROL = 5'b10001,
        OP_SHR = 5'b10010,
        OP_SAR = 5'b10011,
        OP_NOT = 5'b10100,
        OP_ADD = 5'b10101,
        OP_SUB = 5'b10110,
        OP_AND = 5'b10111,
        OP_OR  = 5'b11000,
        OP_XOR = 5'b11001
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_ROTL  = 2'd1,
        SH_RIGHT = 2'd2,
        SH_ARITH = 2'd3
    } shift_mode_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2,
        LG_NOT = 2'd3
    } logic_sel_e;

    typedef enum logic [1:0] {
        GRP_NONE  = 2'd0,
        GRP_ARITH = 2'd1,
        GRP_LOGIC = 2'd2,
        GRP_SHIFT = 2'd3
    } op_group_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
    } alu_flags_t;

endpackage

// File: rtl/alu_shifter.sv
module alu_shifter
    import alu_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int CNT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] src,
    input  logic [CNT_W-1:0] amt,
    input  shift_mode_e      mode,
    output logic [WIDTH-1:0] dst
);

    // Logarithmic barrel: stage k moves by 2**k when amt[k] is set.
    for (genvar k = 0; k < CNT_W; k++) begin : g_stage
        localparam int STEP = 1 << k;
        logic [WIDTH-1:0] cur;
        logic [WIDTH-1:0] moved;
        logic [WIDTH-1:0] q;

        if (k == 0) begin : g_first
            assign cur = src;
        end else begin : g_chain
            assign cur = g_stage[k-1].q;
        end

        always_comb begin
            case (mode)
                SH_LEFT:  moved = {cur[WIDTH-STEP-1:0], {STEP{1'b0}}};
                SH_ROTL:  moved = {cur[WIDTH-STEP-1:0], cur[WIDTH-1:WIDTH-STEP]};
                SH_RIGHT: moved = {{STEP{1'b0}}, cur[WIDTH-1:STEP]};
                default:  moved = {{STEP{cur[WIDTH-1]}}, cur[WIDTH-1:STEP]};
            endcase
        end

        assign q = amt[k] ? moved : cur;
    end

    assign dst = g_stage[CNT_W-1].q;

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   wide;

    // Subtraction as a + ~b + 1; carry out means "no borrow".
    assign b_eff = b ^ {WIDTH{sub}};
    assign wide  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
    assign sum   = wide[WIDTH-1:0];
    assign cout  = wide[WIDTH];

endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic_sel_e       sel,
    output logic [WIDTH-1:0] y
);

    always_comb begin
        case (sel)
            LG_AND:  y = a & b;
            LG_OR:   y = a | b;
            LG_XOR:  y = a ^ b;
            default: y = ~a;
        endcase
    end

endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int CNT_W = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             exec_en,
    input  logic [OPC_W-1:0] opcode,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [CNT_W-1:0] shamt,
    output logic [WIDTH-1:0] result,
    output logic             flag_n,
    output logic             flag_z,
    output logic             flag_c
);

    op_group_e        grp;
    shift_mode_e      sh_mode;
    logic_sel_e       lg_sel;
    logic             is_sub;

    logic [WIDTH-1:0] sh_out;
    logic [WIDTH-1:0] as_out;
    logic             as_cout;
    logic [WIDTH-1:0] lg_out;

    alu_flags_t       flags_d;
    alu_flags_t       flags_q;
    logic [WIDTH-1:0] result_d;

    // Opcode decode into unit controls.
    always_comb begin
        grp     = GRP_NONE;
        sh_mode = SH_LEFT;
        lg_sel  = LG_AND;
        is_sub  = 1'b0;
        case (opcode)
            OP_SHL: begin grp = GRP_SHIFT; sh_mode = SH_LEFT;  end
            OP_ROL: begin grp = GRP_SHIFT; sh_mode = SH_ROTL;  end
            OP_SHR: begin grp = GRP_SHIFT; sh_mode = SH_RIGHT; end
            OP_SAR: begin grp = GRP_SHIFT; sh_mode = SH_ARITH; end
            OP_NOT: begin grp = GRP_LOGIC; lg_sel  = LG_NOT;   end
            OP_ADD: begin grp = GRP_ARITH; is_sub  = 1'b0;     end
            OP_SUB: begin grp = GRP_ARITH; is_sub  = 1'b1;     end
            OP_AND: begin grp = GRP_LOGIC; lg_sel  = LG_AND;   end
            OP_OR:  begin grp = GRP_LOGIC; lg_sel  = LG_OR;    end
            OP_XOR: begin grp = GRP_LOGIC; lg_sel  = LG_XOR;   end
            default: grp = GRP_NONE;
        endcase
    end

    alu_shifter #(
        .WIDTH (WIDTH),
        .CNT_W (CNT_W)
    ) shifter_i (
        .src  (op_a),
        .amt  (shamt),
        .mode (sh_mode),
        .dst  (sh_out)
    );

    alu_addsub #(
        .WIDTH (WIDTH)
    ) addsub_i (
        .a    (op_a),
        .b    (op_b),
        .sub  (is_sub),
        .sum  (as_out),
        .cout (as_cout)
    );

    alu_logic #(
        .WIDTH (WIDTH)
    ) logic_i (
        .a   (op_a),
        .b   (op_b),
        .sel (lg_sel),
        .y   (lg_out)
    );

    // Next-state process: result select and flag update.
    always_comb begin
        flags_d  = flags_q;
        result_d = '0;
        case (grp)
            GRP_ARITH: result_d = as_out;
            GRP_LOGIC: result_d = lg_out;
            GRP_SHIFT: result_d = sh_out;
            default:   result_d = '0;
        endcase
        if (exec_en && grp != GRP_NONE) begin
            flags_d.n = result_d[WIDTH-1];
            flags_d.z = (result_d == '0);
            flags_d.c = (grp == GRP_ARITH) ? as_cout : 1'b0;
        end
    end

    // Register process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign result = result_d;
    assign flag_n = flags_q.n;
    assign flag_z = flags_q.z;
    assign flag_c = flags_q.c;

endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk
    import alu_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int CNT_W = $clog2(WIDTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             exec_en,
    input logic [OPC_W-1:0] opcode,
    input logic [WIDTH-1:0] op_a,
    input logic [CNT_W-1:0] shamt,
    input logic [WIDTH-1:0] result,
    input logic             flag_n,
    input logic             flag_z,
    input logic             flag_c
);

    logic known_op;
    logic shift_op;
    logic nocarry_op;

    assign known_op   = (opcode >= 5'b10000) && (opcode <= 5'b11001);
    assign shift_op   = (opcode >= 5'b10000) && (opcode <= 5'b10011);
    assign nocarry_op = known_op && (opcode != 5'b10101) && (opcode != 5'b10110);

    // R11: flags hold on an idle or unrecognised cycle
    p_flag_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!exec_en || !known_op) |=> ($stable(flag_n) && $stable(flag_z) && $stable(flag_c)));

    // R11: unknown opcode drives zero
    p_unknown_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !known_op |-> (result == '0));

    // R10: zero flag tracks the previous result
    p_zero_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && known_op) |=> (flag_z == ($past(result) == '0)));

    // R10: negative flag tracks the previous sign bit
    p_neg_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && known_op) |=> (flag_n == $past(result[WIDTH-1])));

    // R3: logic and shift operations clear carry
    p_carry_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && nocarry_op) |=> !flag_c);

    // R8: zero amount is a move
    p_zero_amt_move_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_op && shamt == '0) |-> (result == op_a));

    // R9: complement regardless of amount
    p_not_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == 5'b10100) |-> (result == ~op_a));

endmodule

bind alu_core alu_core_chk #(
    .WIDTH (WIDTH),
    .CNT_W (CNT_W)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .exec_en (exec_en),
    .opcode  (opcode),
    .op_a    (op_a),
    .shamt   (shamt),
    .result  (result),
    .flag_n  (flag_n),
    .flag_z  (flag_z),
    .flag_c  (flag_c)
);

// File: tb/alu_core_tb_top.sv
module alu_core_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 32;

    logic          clk;
    logic          rst_n;
    logic          exec_en;
    logic [4:0]    opcode;
    logic [W-1:0]  op_a;
    logic [W-1:0]  op_b;
    logic [4:0]    shamt;
    logic [W-1:0]  result;
    logic          flag_n;
    logic          flag_z;
    logic          flag_c;

    int vectors;
    int errors;
    logic [W-1:0] pats [8];

    alu_core dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .exec_en (exec_en),
        .opcode  (opcode),
        .op_a    (op_a),
        .op_b    (op_b),
        .shamt   (shamt),
        .result  (result),
        .flag_n  (flag_n),
        .flag_z  (flag_z),
        .flag_c  (flag_c)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic string req_of(input logic [4:0] op);
        case (op)
            5'b10101: return "R1";
            5'b10110: return "R2";
            5'b10000: return "R4";
            5'b10001: return "R5";
            5'b10010: return "R6";
            5'b10011: return "R7";
            5'b10100: return "R9";
            default:  return "R3";
        endcase
    endfunction

    // Reference arithmetic, written from the requirements.
    task automatic model(input logic [4:0] op, input logic [W-1:0] a,
                         input logic [W-1:0] b, input logic [4:0] n,
                         output logic [W-1:0] res, output logic c);
        logic [W:0] wide;
        c = 1'b0;
        case (op)
            5'b10000: res = a << n;
            5'b10001: res = (n == 0) ? a : ((a << n) | (a >> (W - n)));
            5'b10010: res = a >> n;
            5'b10011: res = W'($signed(a) >>> n);
            5'b10100: res = ~a;
            5'b10101: begin wide = {1'b0, a} + {1'b0, b}; res = wide[W-1:0]; c = wide[W]; end
            5'b10110: begin res = a - b; c = (a >= b); end
            5'b10111: res = a & b;
            5'b11000: res = a | b;
            5'b11001: res = a ^ b;
            default:  res = '0;
        endcase
    endtask

    task automatic fail_line(input string req, input logic [W+2:0] got, input logic [W+2:0] exp);
        errors++;
        $display("FAIL %s: got result/n/z/c = %h expected %h", req, got, exp);
    endtask

    // Drive at the falling edge, let flags load, compare after the rising edge.
    task automatic run_op(input logic [4:0] op, input logic [W-1:0] a,
                          input logic [W-1:0] b, input logic [4:0] n, input string req);
        logic [W-1:0] er;
        logic ec;
        logic [W+2:0] exp;
        logic [W+2:0] got;
        model(op, a, b, n, er, ec);
        @(negedge clk);
        exec_en = 1'b1; opcode = op; op_a = a; op_b = b; shamt = n;
        @(posedge clk);
        #1;
        vectors++;
        exp = {er, er[W-1], (er == '0), ec};
        got = {result, flag_n, flag_z, flag_c};
        if (got !== exp) fail_line(req, got, exp);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin : stim
        logic [W-1:0] hold_res;
        logic [2:0]   hold_f;
        vectors = 0;
        errors  = 0;
        pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF;
        pats[2] = 32'h8000_0000; pats[3] = 32'h0000_0001;
        pats[4] = 32'hAAAA_5555; pats[5] = 32'h7FFF_FFFF;
        pats[6] = 32'hC3A5_0F96; pats[7] = 32'h1234_5678;
        rst_n = 1'b0; exec_en = 1'b0; opcode = 5'b10101;
        op_a = 32'h8000_0000; op_b = 32'h8000_0000; shamt = '0;
        repeat (3) @(posedge clk);
        #1;
        vectors++;
        // R12: reset state of the flags
        if ({flag_n, flag_z, flag_c} !== 3'b000)
            fail_line("R12", {result, flag_n, flag_z, flag_c}, {result, 3'b000});
        @(negedge clk);
        rst_n = 1'b1;

        // R4 R5 R6 R7 R8: every shift opcode over every amount
        for (int op = 16; op <= 19; op++)
            for (int p = 0; p < 8; p++)
                for (int n = 0; n < 32; n++)
                    run_op(5'(op), pats[p], pats[7 - p], 5'(n),
                           (n == 0) ? "R8" : req_of(5'(op)));

        // R9: complement with every amount
        for (int p = 0; p < 8; p++)
            for (int n = 0; n < 32; n++)
                run_op(5'b10100, pats[p], pats[p], 5'(n), "R9");

        // R1 R2 R3: binary operations over all pattern pairs
        for (int op = 21; op <= 25; op++)
            for (int p = 0; p < 8; p++)
                for (int q = 0; q < 8; q++)
                    run_op(5'(op), pats[p], pats[q], 5'(p + q), req_of(5'(op)));

        // R2: borrow borders
        run_op(5'b10110, 32'd5, 32'd5, 5'd0, "R2");
        run_op(5'b10110, 32'd5, 32'd6, 5'd0, "R2");
        run_op(5'b10110, 32'd6, 32'd5, 5'd0, "R2");

        // R5: left rotate by 32-N equals a right rotate by N
        for (int n = 1; n < 32; n++) begin
            @(negedge clk);
            exec_en = 1'b1; opcode = 5'b10001; op_a = 32'hC3A5_0F96; shamt = 5'(32 - n);
            @(posedge clk);
            #1;
            vectors++;
            if (result !== ((32'hC3A5_0F96 >> n) | (32'hC3A5_0F96 << (32 - n))))
                fail_line("R5", {result, 3'b0},
                          {((32'hC3A5_0F96 >> n) | (32'hC3A5_0F96 << (32 - n))), 3'b0});
        end

        // R11: idle cycle keeps flags; set known flags first (negative, carry 0)
        run_op(5'b10100, 32'h0000_0001, 32'h0, 5'd0, "R9");
        @(negedge clk);
        exec_en = 1'b0; opcode = 5'b10101; op_a = 32'hFFFF_FFFF; op_b = 32'h1;
        @(posedge clk);
        #1;
        vectors++;
        hold_f = {flag_n, flag_z, flag_c};
        if (hold_f !== 3'b100 || result !== 32'h0)
            fail_line("R11", {result, hold_f}, {32'h0, 3'b100});

        // R11: unknown opcode keeps flags and drives zero
        @(negedge clk);
        exec_en = 1'b1; opcode = 5'b00011; op_a = 32'h0; op_b = 32'h0;
        @(posedge clk);
        #1;
        vectors++;
        hold_res = result;
        hold_f   = {flag_n, flag_z, flag_c};
        if (hold_f !== 3'b100 || hold_res !== 32'h0)
            fail_line("R11", {hold_res, hold_f}, {32'h0, 3'b100});

        // R10: flags follow the next enabled operation (zero result)
        run_op(5'b11001, 32'h5A5A_5A5A, 32'h5A5A_5A5A, 5'd0, "R10");
        run_op(5'b10101, 32'h8000_0000, 32'h8000_0000, 5'd0, "R10");

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule